// File: doc/BRIEF.md
# Configuration Address One-Hot Translator

This block sits inside a host bridge, between the CPU side and a downstream configuration port. CPU accesses that land in a 4 MB direct-mapped configuration window are turned into configuration requests. The request address is built from three parts: a device number, the function field and the register offset. The device number is not read from an index register. It is found by a priority search over eleven one-hot select bits in the CPU address. Reads return the downstream data to the CPU. Writes carry their data and byte strobes through unchanged.

A single byte location, separate from the window, serves as the interrupt-acknowledge point. A byte read there returns the vector that is waiting on an input port. A write there is swallowed. Any other access is not claimed by the block and completes with a decode-miss flag.

The CPU side uses a valid/ready handshake. The CPU holds `cpu_valid` and all access fields steady until `cpu_ready` is high. The block then takes one access at a time.

Top module: `cfg_window_xlate`

## Requirements
- R1: An access whose address lies in 0x8080_0000 to 0x80BF_FFFF (address bits 31:22 equal 0x202) issues exactly one downstream configuration request; accesses outside that range issue none.
- R2: The device number sits in `cfg_req_addr[14:11]`. It is the position of the lowest set bit among CPU address bits 21:11, counted as 0 at bit 11 and 10 at bit 21.
- R3: When CPU address bits 21:11 are all zero, the device number is 11.
- R4: CPU address bits 10:0 appear unchanged in `cfg_req_addr[10:0]` as function and register offset.
- R5: `cfg_req_write` follows the CPU direction. On writes, `cfg_req_wdata` and `cfg_req_strb` equal the CPU data and strobes, little-endian: strobe bit 0 covers data bits 7:0.
- R6: While `cfg_req_valid` is high and `cfg_req_ready` is low, the request stays asserted and its address, direction, data and strobes do not change.
- R7: A window read completes with `cpu_rdata` equal to the `cfg_rsp_rdata` returned downstream. `cpu_rvalid` is high for exactly one cycle, the same cycle as `cpu_ready`.
- R8: A read at 0xBFFF_FFF0 with `cpu_size` = 0 (byte; 1 = halfword, 2 = word) issues no request. It returns `{24'b0, iack_vector}`, with `iack_vector` sampled when the access is taken.
- R9: A write of any size to 0xBFFF_FFF0 completes with no request, no `cpu_rvalid` and no `cpu_miss`.
- R10: Any other access completes with `cpu_miss` high in its `cpu_ready` cycle, `cpu_rvalid` low, `cpu_rdata` zero and no request. This includes a non-byte read at 0xBFFF_FFF0 and a read at 0xBFFF_FFF1.
- R11: During and right after reset, `cpu_ready`, `cpu_rvalid`, `cpu_miss` and `cfg_req_valid` are low.
- R12: Every accepted access completes with `cpu_ready` high for exactly one cycle, and the next cycle returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU access request, held until `cpu_ready` |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_addr | input | 32 | CPU byte address |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_wdata | input | 32 | Write data, little-endian lanes |
| cpu_strb | input | 4 | Byte strobes |
| cpu_rvalid | output | 1 | Read data valid pulse |
| cpu_rdata | output | 32 | Read data |
| cpu_miss | output | 1 | Access not claimed (decode miss) |
| iack_vector | input | 8 | Pending interrupt vector |
| cfg_req_valid | output | 1 | Configuration request valid |
| cfg_req_ready | input | 1 | Downstream takes the request |
| cfg_req_addr | output | 15 | Device[14:11], function/offset[10:0] |
| cfg_req_write | output | 1 | Request direction |
| cfg_req_wdata | output | 32 | Request write data |
| cfg_req_strb | output | 4 | Request byte strobes |
| cfg_rsp_valid | input | 1 | Downstream read data valid |
| cfg_rsp_rdata | input | 32 | Downstream read data |

## Verification
Some rules hold on every cycle, and the assertions watch those. They check that a stalled request stays frozen, and that read-valid and completion are single-cycle pulses that coincide. They check that a miss never comes with read data or a request, that every request follows an accepted access, and that the device field never goes above 11. Other behaviour depends on which address arrived, and only the bench scenarios can show it. That covers the priority search choosing the lowest select bit and the all-zero case mapping to 11. It also covers the exact window edges, and the three outcomes at the interrupt-acknowledge byte: vector read, ignored write and oversize read.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  // Classification of one CPU access
  typedef enum logic [1:0] {
    K_CFG     = 2'd0,  // direct configuration window
    K_IACK_RD = 2'd1,  // byte read of interrupt-acknowledge location
    K_IGNORE  = 2'd2,  // write to interrupt-acknowledge location
    K_MISS    = 2'd3   // not claimed
  } acc_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_RSP  = 2'd2,
    S_DONE = 2'd3
  } seq_state_e;

  localparam logic [1:0] SIZE_BYTE = 2'd0;

  // Builds the translated address from device number and low bits
  function automatic logic [31:0] pack_xaddr(input int unsigned dev,
                                             input logic [31:0] low,
                                             input int unsigned low_w);
    return (32'(dev) << low_w) | (low & ((32'd1 << low_w) - 32'd1));
  endfunction

endpackage

// File: rtl/cfgx_window_decode.sv
module cfgx_window_decode
  import cfgx_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       CFG_LOG2  = 22,
  parameter logic [ADDR_W-1:0] CFG_BASE  = 32'h8080_0000,
  parameter logic [ADDR_W-1:0] IACK_ADDR = 32'hBFFF_FFF0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic [1:0]        size,
  output acc_kind_e         kind
);

  logic in_cfg;
  logic hit_iack;

  assign in_cfg   = (addr[ADDR_W-1:CFG_LOG2] == CFG_BASE[ADDR_W-1:CFG_LOG2]);
  assign hit_iack = (addr == IACK_ADDR);

  always_comb begin
    if (in_cfg) begin
      kind = K_CFG;
    end else if (hit_iack) begin
      if (write)                  kind = K_IGNORE;
      else if (size == SIZE_BYTE) kind = K_IACK_RD;
      else                        kind = K_MISS;
    end else begin
      kind = K_MISS;
    end
  end

endmodule

// File: rtl/cfgx_dev_search.sv
module cfgx_dev_search
  import cfgx_pkg::*;
#(
  parameter int unsigned SEL_LO = 11,
  parameter int unsigned SEL_N  = 11,
  parameter int unsigned DEV_W  = 4
) (
  input  logic [SEL_LO+SEL_N-1:0] low_addr,
  output logic [DEV_W+SEL_LO-1:0] xaddr
);

  localparam int unsigned XADDR_W = DEV_W + SEL_LO;

  logic [SEL_N-1:0] sel;
  logic [SEL_N-1:0] win;   // one-hot: lowest set select bit
  logic [DEV_W-1:0] dev;

  assign sel = low_addr[SEL_LO+SEL_N-1:SEL_LO];

  for (genvar i = 0; i < SEL_N; i++) begin : g_prio
    if (i == 0) begin : g_first
      assign win[i] = sel[i];
    end else begin : g_rest
      assign win[i] = sel[i] & ~(|sel[i-1:0]);
    end
  end

  always_comb begin
    dev = DEV_W'(SEL_N);
    for (int i = 0; i < SEL_N; i++) begin
      if (win[i]) dev = DEV_W'(i);
    end
  end

  assign xaddr = XADDR_W'(pack_xaddr(32'(dev), 32'(low_addr), SEL_LO));

endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq
  import cfgx_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned XADDR_W = 15,
  parameter int unsigned IACK_W  = 8,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_valid,
  input  acc_kind_e          kind,
  input  logic [XADDR_W-1:0] xaddr,
  input  logic               cpu_write,
  input  logic [DATA_W-1:0]  cpu_wdata,
  input  logic [STRB_W-1:0]  cpu_strb,
  input  logic [IACK_W-1:0]  iack_vec,
  output logic               cpu_ready,
  output logic               cpu_rvalid,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               cpu_miss,
  output logic               cfg_req_valid,
  input  logic               cfg_req_ready,
  output logic [XADDR_W-1:0] cfg_req_addr,
  output logic               cfg_req_write,
  output logic [DATA_W-1:0]  cfg_req_wdata,
  output logic [STRB_W-1:0]  cfg_req_strb,
  input  logic               cfg_rsp_valid,
  input  logic [DATA_W-1:0]  cfg_rsp_rdata,
  output logic               accept
);

  seq_state_e         state;
  acc_kind_e          kind_q;
  logic [XADDR_W-1:0] xaddr_q;
  logic               write_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [STRB_W-1:0]  strb_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               req_fire;
  logic               rsp_fire;

  assign accept   = (state == S_IDLE) && cpu_valid;
  assign req_fire = (state == S_REQ) && cfg_req_ready;
  assign rsp_fire = (state == S_RSP) && cfg_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      kind_q  <= K_MISS;
      xaddr_q <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
      strb_q  <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          kind_q  <= kind;
          xaddr_q <= xaddr;
          write_q <= cpu_write;
          wdata_q <= cpu_wdata;
          strb_q  <= cpu_strb;
          rdata_q <= (kind == K_IACK_RD) ? DATA_W'(iack_vec) : '0;
          state   <= (kind == K_CFG) ? S_REQ : S_DONE;
        end
        S_REQ: if (req_fire) begin
          state <= write_q ? S_DONE : S_RSP;
        end
        S_RSP: if (rsp_fire) begin
          rdata_q <= cfg_rsp_rdata;
          state   <= S_DONE;
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cfg_req_valid = (state == S_REQ);
  assign cfg_req_addr  = xaddr_q;
  assign cfg_req_write = write_q;
  assign cfg_req_wdata = wdata_q;
  assign cfg_req_strb  = strb_q;

  assign cpu_ready  = (state == S_DONE);
  assign cpu_rvalid = (state == S_DONE) &&
                      ((kind_q == K_IACK_RD) || ((kind_q == K_CFG) && !write_q));
  assign cpu_miss   = (state == S_DONE) && (kind_q == K_MISS);
  assign cpu_rdata  = rdata_q;

endmodule

// File: rtl/cfg_window_xlate.sv
module cfg_window_xlate
  import cfgx_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       SEL_LO    = 11,
  parameter int unsigned       SEL_N     = 11,
  parameter int unsigned       IACK_W    = 8,
  parameter logic [ADDR_W-1:0] CFG_BASE  = 32'h8080_0000,
  parameter logic [ADDR_W-1:0] IACK_ADDR = 32'hBFFF_FFF0,
  localparam int unsigned CFG_LOG2 = SEL_LO + SEL_N,
  localparam int unsigned STRB_W   = DATA_W / 8,
  localparam int unsigned DEV_W    = $clog2(SEL_N + 1),
  localparam int unsigned XADDR_W  = DEV_W + SEL_LO
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_valid,
  output logic               cpu_ready,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               cpu_write,
  input  logic [1:0]         cpu_size,
  input  logic [DATA_W-1:0]  cpu_wdata,
  input  logic [STRB_W-1:0]  cpu_strb,
  output logic               cpu_rvalid,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               cpu_miss,
  input  logic [IACK_W-1:0]  iack_vector,
  output logic               cfg_req_valid,
  input  logic               cfg_req_ready,
  output logic [XADDR_W-1:0] cfg_req_addr,
  output logic               cfg_req_write,
  output logic [DATA_W-1:0]  cfg_req_wdata,
  output logic [STRB_W-1:0]  cfg_req_strb,
  input  logic               cfg_rsp_valid,
  input  logic [DATA_W-1:0]  cfg_rsp_rdata
);

  acc_kind_e          kind;
  logic [XADDR_W-1:0] xaddr;
  logic               accept;

  cfgx_window_decode #(
    .ADDR_W(ADDR_W), .CFG_LOG2(CFG_LOG2),
    .CFG_BASE(CFG_BASE), .IACK_ADDR(IACK_ADDR)
  ) dec_i (
    .addr(cpu_addr), .write(cpu_write), .size(cpu_size), .kind(kind)
  );

  cfgx_dev_search #(
    .SEL_LO(SEL_LO), .SEL_N(SEL_N), .DEV_W(DEV_W)
  ) srch_i (
    .low_addr(cpu_addr[CFG_LOG2-1:0]), .xaddr(xaddr)
  );

  cfgx_seq #(
    .DATA_W(DATA_W), .XADDR_W(XADDR_W), .IACK_W(IACK_W)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .kind(kind),
    .xaddr(xaddr), .cpu_write(cpu_write), .cpu_wdata(cpu_wdata),
    .cpu_strb(cpu_strb), .iack_vec(iack_vector),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .cpu_miss(cpu_miss), .cfg_req_valid(cfg_req_valid),
    .cfg_req_ready(cfg_req_ready), .cfg_req_addr(cfg_req_addr),
    .cfg_req_write(cfg_req_write), .cfg_req_wdata(cfg_req_wdata),
    .cfg_req_strb(cfg_req_strb), .cfg_rsp_valid(cfg_rsp_valid),
    .cfg_rsp_rdata(cfg_rsp_rdata), .accept(accept)
  );

endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned XADDR_W = 15,
  parameter int unsigned SEL_LO  = 11,
  parameter int unsigned SEL_N   = 11,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_ready,
  input logic               cpu_rvalid,
  input logic               cpu_miss,
  input logic               cfg_req_valid,
  input logic               cfg_req_ready,
  input logic [XADDR_W-1:0] cfg_req_addr,
  input logic               cfg_req_write,
  input logic [DATA_W-1:0]  cfg_req_wdata,
  input logic [STRB_W-1:0]  cfg_req_strb,
  input logic               accept
);

  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && !cfg_req_ready |=> cfg_req_valid && $stable(cfg_req_addr)
      && $stable(cfg_req_write) && $stable(cfg_req_wdata) && $stable(cfg_req_strb));

  a_r7_rvalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |=> !cpu_rvalid);

  a_r7_rvalid_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> cpu_ready);

  a_r10_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_miss |-> !cpu_rvalid && !cfg_req_valid);

  a_r2_dev_range: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> (32'(cfg_req_addr[XADDR_W-1:SEL_LO]) <= SEL_N));

  a_r1_req_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req_valid) |-> $past(accept));

  a_r12_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

endmodule

bind cfg_window_xlate cfgx_checker #(
  .DATA_W(DATA_W), .XADDR_W(XADDR_W), .SEL_LO(SEL_LO), .SEL_N(SEL_N)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid),
  .cpu_miss(cpu_miss), .cfg_req_valid(cfg_req_valid),
  .cfg_req_ready(cfg_req_ready), .cfg_req_addr(cfg_req_addr),
  .cfg_req_write(cfg_req_write), .cfg_req_wdata(cfg_req_wdata),
  .cfg_req_strb(cfg_req_strb), .accept(accept)
);

// File: tb/cfg_window_xlate_tb.sv
`timescale 1ns/1ps
module cfg_window_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_valid, cpu_ready, cpu_write, cpu_rvalid, cpu_miss;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic [1:0]  cpu_size;
  logic [3:0]  cpu_strb;
  logic [7:0]  iack_vector;
  logic        cfg_req_valid, cfg_req_ready, cfg_req_write, cfg_rsp_valid;
  logic [14:0] cfg_req_addr;
  logic [31:0] cfg_req_wdata, cfg_rsp_rdata;
  logic [3:0]  cfg_req_strb;

  always #4 clk = ~clk;  // 125 MHz

  cfg_window_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_addr(cpu_addr), .cpu_write(cpu_write), .cpu_size(cpu_size),
    .cpu_wdata(cpu_wdata), .cpu_strb(cpu_strb), .cpu_rvalid(cpu_rvalid),
    .cpu_rdata(cpu_rdata), .cpu_miss(cpu_miss), .iack_vector(iack_vector),
    .cfg_req_valid(cfg_req_valid), .cfg_req_ready(cfg_req_ready),
    .cfg_req_addr(cfg_req_addr), .cfg_req_write(cfg_req_write),
    .cfg_req_wdata(cfg_req_wdata), .cfg_req_strb(cfg_req_strb),
    .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_rdata(cfg_rsp_rdata)
  );

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic [1:0]  size;
    logic [31:0] data;
    logic [3:0]  strb;
    logic [1:0]  dly;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h8080_0000, 1'b0, 2'd2, 32'h0000_0000, 4'hF, 2'd0},
    '{32'h8080_0804, 1'b1, 2'd2, 32'h1122_3344, 4'hF, 2'd1},
    '{32'h8080_1A10, 1'b0, 2'd2, 32'h0000_0000, 4'hF, 2'd2},
    '{32'h8080_27FF, 1'b1, 2'd0, 32'h0000_00AB, 4'h1, 2'd0},
    '{32'h80A0_0000, 1'b0, 2'd2, 32'h0000_0000, 4'hF, 2'd3},
    '{32'h80B0_0400, 1'b1, 2'd2, 32'hCAFE_F00D, 4'hC, 2'd0},
    '{32'h80C0_0000, 1'b0, 2'd2, 32'h0000_0000, 4'hF, 2'd0},
    '{32'h807F_FFFC, 1'b1, 2'd2, 32'h7777_7777, 4'hF, 2'd0},
    '{32'hBFFF_FFF0, 1'b0, 2'd0, 32'h0000_0000, 4'h1, 2'd0},
    '{32'hBFFF_FFF0, 1'b1, 2'd0, 32'h0000_0099, 4'h1, 2'd0},
    '{32'hBFFF_FFF0, 1'b0, 2'd2, 32'h0000_0000, 4'hF, 2'd0},
    '{32'hBFFF_FFF1, 1'b0, 2'd0, 32'h0000_0000, 4'h2, 2'd0}
  };

  // observations of one access
  int          n_req;
  logic        stable_ok, timed_out;
  logic [14:0] r_addr;
  logic        r_write;
  logic [31:0] r_wdata;
  logic [3:0]  r_strb;
  logic        o_rvalid, o_miss, o_after_ready, o_after_rvalid;
  logic [31:0] o_rdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bench's own device-number model: walk upward through the select bits
  function automatic int ref_dev(input logic [31:0] a);
    int k = 0;
    while (k < 11 && a[11+k] == 1'b0) k++;
    return k;
  endfunction

  task automatic run_access(input logic [31:0] a, input logic wr, input logic [1:0] sz,
                            input logic [31:0] d, input logic [3:0] st,
                            input int dly, input logic [31:0] rsp);
    int   waited = 0;
    int   guard  = 0;
    logic held   = 1'b0;
    logic fired  = 1'b0;
    n_req = 0; stable_ok = 1'b1; timed_out = 1'b0;
    o_rvalid = 1'b0; o_rdata = '0; o_miss = 1'b0;
    r_addr = '0; r_write = 1'b0; r_wdata = '0; r_strb = '0;
    cpu_addr = a; cpu_write = wr; cpu_size = sz; cpu_wdata = d; cpu_strb = st;
    cpu_valid = 1'b1;
    forever begin
      @(negedge clk);
      guard++;
      cfg_rsp_valid = 1'b0;
      if (fired) begin
        fired = 1'b0;
        if (!r_write) begin
          cfg_rsp_valid = 1'b1;
          cfg_rsp_rdata = rsp;
        end
      end
      if (cfg_req_valid) begin
        if (held && (cfg_req_addr !== r_addr || cfg_req_write !== r_write ||
                     cfg_req_wdata !== r_wdata || cfg_req_strb !== r_strb))
          stable_ok = 1'b0;
        if (!held) n_req++;
        r_addr = cfg_req_addr; r_write = cfg_req_write;
        r_wdata = cfg_req_wdata; r_strb = cfg_req_strb;
        held = 1'b1;
        if (waited >= dly) begin
          cfg_req_ready = 1'b1; fired = 1'b1; held = 1'b0;
        end else begin
          cfg_req_ready = 1'b0; waited++;
        end
      end else begin
        cfg_req_ready = 1'b0;
      end
      if (cpu_ready) begin
        o_rvalid = cpu_rvalid; o_rdata = cpu_rdata; o_miss = cpu_miss;
        break;
      end
      if (guard > 40) begin
        timed_out = 1'b1;
        break;
      end
    end
    @(negedge clk);
    cpu_valid = 1'b0; cfg_req_ready = 1'b0; cfg_rsp_valid = 1'b0;
    o_after_ready = cpu_ready; o_after_rvalid = cpu_rvalid;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; cpu_valid = 1'b0; cpu_addr = '0; cpu_write = 1'b0;
    cpu_size = '0; cpu_wdata = '0; cpu_strb = '0; iack_vector = 8'h5E;
    cfg_req_ready = 1'b0; cfg_rsp_valid = 1'b0; cfg_rsp_rdata = '0;
    repeat (3) @(negedge clk);
    // R11: outputs quiet in reset
    chk("R11 reset cpu_ready", 32'(cpu_ready), 32'd0);
    chk("R11 reset req_valid", 32'(cfg_req_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 post-reset flags", {29'd0, cpu_rvalid, cpu_miss, cpu_ready}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      logic is_cfg  = (v.addr >= 32'h8080_0000) && (v.addr < 32'h80C0_0000);
      logic is_iack = (v.addr == 32'hBFFF_FFF0);
      logic iack_rd = is_iack && !v.wr && v.size == 2'd0;
      logic is_miss = !is_cfg && !is_iack || (is_iack && !v.wr && v.size != 2'd0);
      logic [31:0] rsp = ~v.addr;
      int dev = ref_dev(v.addr);
      logic [31:0] exp_x = (32'(dev) << 11) | (v.addr & 32'h7FF);
      run_access(v.addr, v.wr, v.size, v.data, v.strb, int'(v.dly), rsp);
      chk("R12 completes", 32'(timed_out), 32'd0);
      chk("R1 request count", n_req, is_cfg ? 1 : 0);
      chk("R12 ready one cycle", 32'(o_after_ready), 32'd0);
      chk("R7 rvalid one cycle", 32'(o_after_rvalid), 32'd0);
      if (is_cfg) begin
        chk(dev == 11 ? "R3 device none set" : "R2 device number",
            32'(r_addr[14:11]), 32'(dev));
        chk("R4 low bits", 32'(r_addr[10:0]), exp_x & 32'h7FF);
        chk("R5 direction", 32'(r_write), 32'(v.wr));
        chk("R6 held stable", 32'(stable_ok), 32'd1);
        if (v.wr) begin
          chk("R5 wdata", r_wdata, v.data);
          chk("R5 strobes", 32'(r_strb), 32'(v.strb));
          chk("R5 no rvalid on write", 32'(o_rvalid), 32'd0);
        end else begin
          chk("R7 rvalid", 32'(o_rvalid), 32'd1);
          chk("R7 rdata", o_rdata, rsp);
        end
        chk("R1 no miss", 32'(o_miss), 32'd0);
      end else if (iack_rd) begin
        chk("R8 rvalid", 32'(o_rvalid), 32'd1);
        chk("R8 vector", o_rdata, 32'h0000_005E);
        chk("R8 no miss", 32'(o_miss), 32'd0);
      end else if (is_miss) begin
        chk("R10 miss flag", 32'(o_miss), 32'd1);
        chk("R10 no rvalid", 32'(o_rvalid), 32'd0);
        chk("R10 rdata zero", o_rdata, 32'd0);
      end else begin
        chk("R9 no rvalid", 32'(o_rvalid), 32'd0);
        chk("R9 no miss", 32'(o_miss), 32'd0);
      end
    end

    // R8: vector sampled when accepted, new value per read
    iack_vector = 8'hC3;
    run_access(32'hBFFF_FFF0, 1'b0, 2'd0, 32'd0, 4'h1, 0, 32'd0);
    chk("R8 vector second read", o_rdata, 32'h0000_00C3);
    // R9: ignored write leaves next read of the vector unaffected
    run_access(32'hBFFF_FFF0, 1'b1, 2'd0, 32'h0000_0011, 4'h1, 0, 32'd0);
    chk("R9 write no request", n_req, 0);
    run_access(32'hBFFF_FFF0, 1'b0, 2'd0, 32'd0, 4'h1, 0, 32'd0);
    chk("R9 vector after write", o_rdata, 32'h0000_00C3);
    // R2: highest select bit alone, long stall for R6
    run_access(32'h80A0_07FC, 1'b0, 2'd2, 32'd0, 4'hF, 3, 32'h1357_9BDF);
    chk("R2 device ten", 32'(r_addr[14:11]), 32'd10);
    chk("R6 stable long stall", 32'(stable_ok), 32'd1);
    chk("R7 rdata stalled", o_rdata, 32'h1357_9BDF);
    // R1: last byte of the window is claimed
    run_access(32'h80BF_FFFF, 1'b1, 2'd0, 32'hFF00_0000, 4'h8, 0, 32'd0);
    chk("R1 window top claimed", n_req, 1);
    chk("R5 lane 3 strobe", 32'(r_strb), 32'h8);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule